// File: doc/BRIEF.md
# Remappable Priority Interrupt Controller

This block gathers up to 64 interrupt request lines and tells the processor which one to take next. Every source has a fixed default level (1 to 7) and a fixed priority inside that level. The controller picks the highest pending request, tests it against a 3-bit mask register, and presents the winner's level and vector number on registered outputs. Level 7 is non-maskable and edge-triggered. Levels 1 to 6 are level-sensitive and are governed by the mask.

Software can use two remap registers to lift any two sources above every other level-6 request. A one-cycle acknowledge from the core takes the presented request. The acknowledge clears the edge latch of a level-7 source, and it can optionally load the mask with 7 so that the handler starts with maskable interrupts blocked. An inhibit input freezes the presented request while the core is not sampling, such as during the first instruction of a handler.

Top module: `irq_prio_ctrl`

## Requirements
- R1: After a synchronous active-low reset, `irq_level` is 0, `irq_vector` is 0 and `mask_level` is 7. Both remap registers hold 0 and auto-mask is off.
- R2: For source s, with g = (s+12)>>3, the default level is g, or g-7 when g exceeds 7. The default priority is (11 - ((s+12) mod 8)) mod 8. The vector is 64+s. Source 0 never requests. For example, source 20 is level 4, priority 3, vector 84, and source 21 is level 4, priority 2, vector 85.
- R3: The presented request is the pending request with the highest level. Ties are broken by the highest priority and then by the higher source number.
- R4: A level-1 to level-6 request is presented only when its level is greater than `mask_level`. Register address 0 sets the mask from `wr_data[2:0]`. `irq_level` = 0 means that no request is presented, and `irq_vector` is 0 in that case.
- R5: A rising edge on a level-7 line is latched, including a one-cycle pulse, and is presented even when the mask is 7. A line that stays high after its edge has been acknowledged is not presented again until it falls and rises.
- R6: Remap slot A (address 1, source number in `wr_data`) places its source at level 6, above every other level-6 request. Slot B (address 2) places its source at level 6, directly below slot A. If both slots name the same source, slot A applies.
- R7: A remap value of 0 means no remap. A remapped source no longer competes at its default level and priority.
- R8: An acknowledge while a request is presented sets `irq_level` to 0 in the next cycle and clears the level-7 latch of that source. A maskable line that stays high is presented again in the following cycle.
- R9: Address 3 bit 0 enables auto-mask. With auto-mask on, an acknowledge of a presented request loads `mask_level` with 7. This takes precedence over a mask write in the same cycle.
- R10: While `inhibit` is high, `irq_level` and `irq_vector` hold their values. An acknowledge in the same cycle still takes effect.
- R11: An acknowledge while nothing is presented has no effect: the mask is unchanged even with auto-mask on.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_req | input | 64 | Interrupt request lines, one bit per source |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mask, 1 remap A, 2 remap B, 3 control |
| wr_data | input | 6 | Register write data |
| ack | input | 1 | One-cycle acknowledge of the presented request |
| inhibit | input | 1 | Freeze the presented request while high |
| irq_level | output | 3 | Level of the presented request, 0 when none |
| irq_vector | output | 8 | Vector of the presented request, 0 when none |
| mask_level | output | 3 | Current interrupt mask |

## Verification
Arbitration is tried in four ways, and each separates one source of ordering from the others:
- Requests from one level at a time show the priority order inside a level.
- Requests stacked across levels show that level dominates priority.
- A pair of sources sharing both level and priority exposes the tie-break on source number.
- The remap slots are driven against the strongest default level-6 source and against a masked default level.

A single source at each of levels 1 to 6 is swept through all eight mask values to pin the exact threshold. Level-7 lines are driven as held highs, re-edges and one-cycle pulses under mask 7. These cases separate edge latching from level sensing, and together with the acknowledge, auto-mask and inhibit sequences they show which event takes precedence.

// File: rtl/irq_prio_pkg.sv
// Package: shared parameters and default source table for the interrupt controller.
// Assumes source numbers fit in SRC_W bits and levels in LVL_W bits.
package irq_prio_pkg;
    localparam int NSRC     = 64;
    localparam int SRC_W    = $clog2(NSRC);
    localparam int LVL_W    = 3;
    localparam int PRI_W    = 3;
    localparam int VEC_W    = 8;
    localparam int VEC_BASE = 64;
    localparam int LVL_MAX  = (1 << LVL_W) - 1;

    // Default level of a source: groups of eight, folded back above the top level.
    function automatic logic [LVL_W-1:0] dflt_level(input int s);
        int g;
        g = (s + 12) >> 3;
        if (g > LVL_MAX) g = g - LVL_MAX;
        return LVL_W'(g);
    endfunction

    // Default priority of a source inside its level.
    function automatic logic [PRI_W-1:0] dflt_prio(input int s);
        return PRI_W'((11 - ((s + 12) & 7)) & 7);
    endfunction
endpackage

// File: rtl/irq_edge_capture.sv
// Edge capture: latches rising edges of every request line, for level-7 use.
// Assumes the clear index names the source that was just acknowledged.
module irq_edge_capture
    import irq_prio_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       req,
    input  logic               clr_en,
    input  logic [SRC_W-1:0]   clr_idx,
    output logic [N-1:0]       pend_edge
);
    logic [N-1:0] req_q;
    logic [N-1:0] rise;

    assign rise = req & ~req_q;

    // Delay the request lines by one cycle for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_q <= '0;
        else        req_q <= req;
    end

    for (genvar gi = 0; gi < N; gi++) begin : g_bit
        // Set a latch on a rising edge; acknowledge of this source clears it.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend_edge[gi] <= 1'b0;
            else if (clr_en && (clr_idx == SRC_W'(gi)))
                pend_edge[gi] <= rise[gi];
            else if (rise[gi])
                pend_edge[gi] <= 1'b1;
        end
    end

    // R5: an acknowledged latch is empty unless a fresh edge arrived with the clear.
    assert_edge_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(clr_en) && !$past(rise[clr_idx])) |-> !pend_edge[$past(clr_idx)]);
endmodule

// File: rtl/irq_rank.sv
// Rank: builds each source's effective level, priority and key, applies the
// remap slots and the mask, and picks the single strongest pending request.
// Assumes remap value 0 means "unused"; source 0 never competes.
module irq_rank
    import irq_prio_pkg::*;
#(
    parameter int N = NSRC
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N-1:0]       req,
    input  logic [N-1:0]       pend_edge,
    input  logic [LVL_W-1:0]   mask_lvl,
    input  logic [SRC_W-1:0]   remap_a,
    input  logic [SRC_W-1:0]   remap_b,
    output logic               win_valid,
    output logic [SRC_W-1:0]   win_src,
    output logic [LVL_W-1:0]   win_lvl
);
    localparam int KEY_W = LVL_W + 2 + PRI_W + SRC_W;

    logic [N-1:0]     qual;
    logic [KEY_W-1:0] key   [N];
    logic [LVL_W-1:0] level [N];

    for (genvar gi = 0; gi < N; gi++) begin : g_src
        logic             hit_a;
        logic             hit_b;
        logic [LVL_W-1:0] lvl;
        logic [PRI_W-1:0] pri;
        logic [1:0]       top;
        logic             pend;

        // Resolve remap slots, then fall back to the default table.
        always_comb begin
            hit_a = (remap_a == SRC_W'(gi)) && (remap_a != '0);
            hit_b = !hit_a && (remap_b == SRC_W'(gi)) && (remap_b != '0);
            if (hit_a) begin
                lvl = LVL_W'(6); pri = PRI_W'(7); top = 2'd2;
            end else if (hit_b) begin
                lvl = LVL_W'(6); pri = PRI_W'(6); top = 2'd1;
            end else begin
                lvl = dflt_level(gi); pri = dflt_prio(gi); top = 2'd0;
            end
            pend = (lvl == LVL_W'(LVL_MAX)) ? pend_edge[gi] : req[gi];
        end

        assign qual[gi]  = (gi != 0) && pend &&
                           ((lvl == LVL_W'(LVL_MAX)) || (lvl > mask_lvl));
        assign key[gi]   = {lvl, top, pri, SRC_W'(gi)};
        assign level[gi] = lvl;
    end

    logic [KEY_W-1:0] best_key;

    // Linear max search over all qualified keys.
    always_comb begin
        best_key  = '0;
        win_valid = 1'b0;
        win_src   = '0;
        win_lvl   = '0;
        for (int s = 0; s < N; s++) begin
            if (qual[s] && (!win_valid || key[s] > best_key)) begin
                best_key  = key[s];
                win_valid = 1'b1;
                win_src   = SRC_W'(s);
                win_lvl   = level[s];
            end
        end
    end

    // R4: a winner is either non-maskable or above the mask.
    assert_win_above_mask_R4: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> ((win_lvl == LVL_W'(LVL_MAX)) || (win_lvl > mask_lvl)));
    // R6: a pending slot-A source beats everything below level 7.
    assert_remap_a_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ((remap_a != '0) && req[remap_a] && (mask_lvl < LVL_W'(6)) &&
         (win_lvl != LVL_W'(LVL_MAX))) |-> (win_valid && (win_src == remap_a)));
endmodule

// File: rtl/irq_ctrl_regs.sv
// Control registers: mask, two remap slots and the auto-mask enable.
// Assumes an acknowledge with auto-mask outranks a same-cycle mask write.
module irq_ctrl_regs
    import irq_prio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [SRC_W-1:0]   wr_data,
    input  logic               ack_take,
    output logic [LVL_W-1:0]   mask_lvl,
    output logic [SRC_W-1:0]   remap_a,
    output logic [SRC_W-1:0]   remap_b,
    output logic               auto_en
);
    // Mask register: auto-load on acknowledge, otherwise software write.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mask_lvl <= LVL_W'(LVL_MAX);
        else if (ack_take && auto_en)
            mask_lvl <= LVL_W'(LVL_MAX);
        else if (wr_en && wr_addr == 2'd0)
            mask_lvl <= wr_data[LVL_W-1:0];
    end

    // Remap slots and the control bit, written by software only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            remap_a <= '0;
            remap_b <= '0;
            auto_en <= 1'b0;
        end else if (wr_en) begin
            case (wr_addr)
                2'd1:    remap_a <= wr_data;
                2'd2:    remap_b <= wr_data;
                2'd3:    auto_en <= wr_data[0];
                default: ;
            endcase
        end
    end

    // R9: an auto-masked acknowledge always leaves the mask at 7.
    assert_auto_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ack_take && auto_en) |-> (mask_lvl == LVL_W'(LVL_MAX)));
endmodule

// File: rtl/irq_prio_ctrl.sv
// Top: registers the winning request for the core, handles acknowledge and
// sampling inhibit. Assumes ack is a single-cycle pulse from the core.
module irq_prio_ctrl
    import irq_prio_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NSRC-1:0]    irq_req,
    input  logic               wr_en,
    input  logic [1:0]         wr_addr,
    input  logic [SRC_W-1:0]   wr_data,
    input  logic               ack,
    input  logic               inhibit,
    output logic [LVL_W-1:0]   irq_level,
    output logic [VEC_W-1:0]   irq_vector,
    output logic [LVL_W-1:0]   mask_level
);
    logic [NSRC-1:0]  pend_edge;
    logic [LVL_W-1:0] mask_lvl;
    logic [SRC_W-1:0] remap_a;
    logic [SRC_W-1:0] remap_b;
    logic             auto_en;
    logic             win_valid;
    logic [SRC_W-1:0] win_src;
    logic [LVL_W-1:0] win_lvl;
    logic [LVL_W-1:0] pres_lvl;
    logic [SRC_W-1:0] pres_src;
    logic             ack_take;

    assign ack_take = ack && (pres_lvl != '0);

    irq_edge_capture #(.N(NSRC)) u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (irq_req),
        .clr_en    (ack_take),
        .clr_idx   (pres_src),
        .pend_edge (pend_edge)
    );

    irq_ctrl_regs u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ack_take (ack_take),
        .mask_lvl (mask_lvl),
        .remap_a  (remap_a),
        .remap_b  (remap_b),
        .auto_en  (auto_en)
    );

    irq_rank #(.N(NSRC)) u_rank (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (irq_req),
        .pend_edge (pend_edge),
        .mask_lvl  (mask_lvl),
        .remap_a   (remap_a),
        .remap_b   (remap_b),
        .win_valid (win_valid),
        .win_src   (win_src),
        .win_lvl   (win_lvl)
    );

    // Presentation register: ack empties it, inhibit freezes it, else track winner.
    always_ff @(posedge clk) begin
        if (!rst_n || ack_take) begin
            pres_lvl <= '0;
            pres_src <= '0;
        end else if (!inhibit) begin
            pres_lvl <= win_valid ? win_lvl : '0;
            pres_src <= win_valid ? win_src : '0;
        end
    end

    assign irq_level  = pres_lvl;
    assign irq_vector = (pres_lvl != '0) ? (VEC_W'(VEC_BASE) + VEC_W'(pres_src)) : '0;
    assign mask_level = mask_lvl;

    // R8: the cycle after a taken acknowledge presents nothing.
    assert_ack_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $past(ack_take) |-> (irq_level == '0));
    // R10: inhibit without acknowledge holds the presented request.
    assert_inhibit_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $past(inhibit && !ack) |-> ($stable(irq_level) && $stable(irq_vector)));
    // R2: any presented vector lies at or above the vector base.
    assert_vector_base_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_level != '0) |-> (irq_vector >= VEC_W'(VEC_BASE)));
endmodule

// File: tb/irq_prio_ctrl_bench.sv
`timescale 1ns/1ps
module irq_prio_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] irq_req = '0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [5:0]  wr_data = '0;
    logic        ack = 1'b0;
    logic        inhibit = 1'b0;
    logic [2:0]  irq_level;
    logic [7:0]  irq_vector;
    logic [2:0]  mask_level;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    irq_prio_ctrl u_irq_prio_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .ack(ack), .inhibit(inhibit),
        .irq_level(irq_level), .irq_vector(irq_vector), .mask_level(mask_level)
    );

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string tag, input logic [2:0] lvl, input logic [7:0] vec);
        checks++;
        if (irq_level !== lvl || irq_vector !== vec) begin
            fails++;
            $display("FAIL %s level/vector actual=%0d/%0d expected=%0d/%0d",
                     tag, irq_level, irq_vector, lvl, vec);
        end
    endtask

    task automatic chk_mask(input string tag, input logic [2:0] m);
        checks++;
        if (mask_level !== m) begin
            fails++;
            $display("FAIL %s mask actual=%0d expected=%0d", tag, mask_level, m);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [5:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic pulse_ack();
        ack = 1'b1;
        step(1);
        ack = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", 3'd0, 8'd0);
        chk_mask("R1", 3'd7);
    endtask

    task automatic t_default();
        wr(2'd0, 6'd0);
        irq_req[20] = 1'b1; irq_req[21] = 1'b1;
        step(3); chk("R2", 3'd4, 8'd84);
        irq_req[20] = 1'b0;
        step(3); chk("R2", 3'd4, 8'd85);
        irq_req[20] = 1'b1; irq_req[27] = 1'b1;
        step(3); chk("R3", 3'd4, 8'd91);
        irq_req[30] = 1'b1;
        step(3); chk("R3", 3'd5, 8'd94);
        irq_req[40] = 1'b1;
        step(3); chk("R3", 3'd6, 8'd104);
        irq_req = '0;
        irq_req[1] = 1'b1; irq_req[57] = 1'b1;
        step(3); chk("R3", 3'd1, 8'd121);
        irq_req = '0;
        irq_req[0] = 1'b1;
        step(3); chk("R2", 3'd0, 8'd0);
        irq_req = '0;
    endtask

    task automatic t_remap();
        wr(2'd1, 6'd20); wr(2'd2, 6'd21);
        irq_req[20] = 1'b1; irq_req[21] = 1'b1; irq_req[40] = 1'b1;
        step(3); chk("R6", 3'd6, 8'd84);
        irq_req[20] = 1'b0;
        step(3); chk("R6", 3'd6, 8'd85);
        irq_req[21] = 1'b0;
        step(3); chk("R6", 3'd6, 8'd104);
        irq_req = '0;
        wr(2'd2, 6'd20);
        irq_req[20] = 1'b1; irq_req[40] = 1'b1;
        step(3); chk("R6", 3'd6, 8'd84);
        wr(2'd1, 6'd0);
        step(3); chk("R6", 3'd6, 8'd84);
        irq_req = '0;
        wr(2'd2, 6'd0);
        wr(2'd1, 6'd27); wr(2'd0, 6'd5);
        irq_req[27] = 1'b1; irq_req[20] = 1'b1;
        step(3); chk("R7", 3'd6, 8'd91);
        wr(2'd0, 6'd6);
        step(3); chk("R7", 3'd0, 8'd0);
        wr(2'd1, 6'd0); wr(2'd0, 6'd0);
        irq_req[27] = 1'b0;
        step(3); chk("R7", 3'd4, 8'd84);
        irq_req = '0;
    endtask

    task automatic t_mask_sweep();
        int srcs [6] = '{1, 5, 12, 20, 30, 36};
        for (int i = 0; i < 6; i++) begin
            irq_req = '0;
            irq_req[srcs[i]] = 1'b1;
            for (int m = 0; m < 8; m++) begin
                wr(2'd0, 6'(m));
                step(3);
                if (i + 1 > m) chk("R4", 3'(i + 1), 8'(64 + srcs[i]));
                else           chk("R4", 3'd0, 8'd0);
            end
        end
        irq_req = '0;
    endtask

    task automatic t_level7();
        wr(2'd0, 6'd7);
        irq_req[36] = 1'b1; irq_req[44] = 1'b1;
        step(3); chk("R5", 3'd7, 8'd108);
        pulse_ack(); chk("R8", 3'd0, 8'd0);
        step(3); chk("R5", 3'd0, 8'd0);
        irq_req[44] = 1'b0; step(1);
        irq_req[44] = 1'b1;
        step(3); chk("R5", 3'd7, 8'd108);
        pulse_ack(); step(2);
        irq_req[45] = 1'b1; step(1); irq_req[45] = 1'b0;
        step(3); chk("R5", 3'd7, 8'd109);
        pulse_ack(); step(3); chk("R5", 3'd0, 8'd0);
        irq_req = '0;
    endtask

    task automatic t_ack_level();
        wr(2'd0, 6'd0);
        irq_req[20] = 1'b1;
        step(3); chk("R8", 3'd4, 8'd84);
        pulse_ack(); chk("R8", 3'd0, 8'd0);
        step(2); chk("R8", 3'd4, 8'd84);
        chk_mask("R9", 3'd0);
    endtask

    task automatic t_automask();
        wr(2'd3, 6'd1);
        step(3); chk("R9", 3'd4, 8'd84);
        pulse_ack(); chk_mask("R9", 3'd7);
        step(3); chk("R9", 3'd0, 8'd0);
        wr(2'd0, 6'd0);
        step(3); chk("R9", 3'd4, 8'd84);
        ack = 1'b1; wr_en = 1'b1; wr_addr = 2'd0; wr_data = 6'd2;
        step(1);
        ack = 1'b0; wr_en = 1'b0;
        chk_mask("R9", 3'd7);
        irq_req = '0;
        wr(2'd0, 6'd0);
        step(3);
        pulse_ack(); step(1); chk_mask("R11", 3'd0);
        chk("R11", 3'd0, 8'd0);
        wr(2'd3, 6'd0);
    endtask

    task automatic t_inhibit();
        irq_req[20] = 1'b1;
        step(3); chk("R10", 3'd4, 8'd84);
        inhibit = 1'b1; irq_req[40] = 1'b1;
        step(3); chk("R10", 3'd4, 8'd84);
        inhibit = 1'b0;
        step(1); chk("R10", 3'd6, 8'd104);
        irq_req[40] = 1'b0;
        step(3); chk("R10", 3'd4, 8'd84);
        ack = 1'b1; inhibit = 1'b1;
        step(1); ack = 1'b0;
        step(2); chk("R10", 3'd0, 8'd0);
        inhibit = 1'b0;
        step(1); chk("R10", 3'd4, 8'd84);
        irq_req = '0;
    endtask

    initial begin
        step(4);
        rst_n = 1'b1;
        step(1);
        t_reset();
        t_default();
        t_remap();
        t_mask_sweep();
        t_level7();
        t_ack_level();
        t_automask();
        t_inhibit();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            checks++; fails++;
            $display("FAIL R1 watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule